// File: doc/BRIEF.md
# Interleaved Pipelined Group Reducer

This block folds a fixed-length vector of unsigned elements into a single sum. It works on streams: each cycle, one group of CONC elements may arrive on a wide input bus. A registered binary tree collapses the group to one value per cycle. That value is then folded into one of PIPESTEP partial accumulators, chosen in round-robin order. The fold operator is an adder placed behind LATENCY register stages, and it can accept new work every cycle.

Because consecutive groups go to different accumulators, a group never waits for the previous fold to finish, so the input stream never stalls. The only rule is that PIPESTEP is at least LATENCY. The block counts TOTAL/CONC groups. When the last fold has drained, it merges the written accumulators through the same multi-cycle operator and presents the result with a one-cycle strobe.

A controller starts each vector with a one-cycle start pulse and then streams the groups. Cycles without a valid group may appear anywhere in the stream.

Top module: `grp_fold_reducer`

## Requirements
- R1: After start, exactly ROUNDS = TOTAL/CONC valid groups are accepted (TOTAL is a multiple of CONC). Further valid groups are ignored until the next start. Each run yields exactly one result.
- R2: The result equals the sum, modulo 2^ACC_W, of every element in the accepted groups. Element k of a group is the unsigned value at in_data bits [k*WIDTH +: WIDTH].
- R3: Groups can be accepted on consecutive cycles with no stall. Cycles with in_valid low contribute nothing and do not change the result.
- R4: A group is reduced by a pipelined tree that pairs neighbours level by level, and the result is correct when CONC is not a power of two.
- R5: Group r goes to accumulator r mod PIPESTEP, and the result is correct both when PIPESTEP equals LATENCY and when it exceeds it.
- R6: When ROUNDS is smaller than PIPESTEP, only the accumulators that received a group take part in the final merge.
- R7: res_valid is high for exactly one cycle per result. res_data keeps its value until the next result.
- R8: A start pulse during a run discards all earlier groups. The next result covers only groups accepted after the latest start.
- R9: After reset, res_valid and res_data are 0. Groups presented before the first start are ignored and produce no result.
- R10: A group presented in the same cycle as start is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a new vector |
| in_valid | input | 1 | in_data carries a group this cycle |
| in_data | input | CONC*WIDTH | Group of CONC unsigned elements, element k at bits k*WIDTH |
| res_valid | output | 1 | One-cycle strobe: res_data holds a new result |
| res_data | output | ACC_W | Reduced value of the last completed vector |

## Verification
The hardest case to reach is an accumulator being read in the same cycle that the operator writes back its previous fold. This only happens when groups arrive back to back and PIPESTEP equals LATENCY, so that the forwarding path carries the value. The bench creates it with gap-free runs on an instance where PIPESTEP equals LATENCY. It then mixes in runs with random idle cycles, which push the reuse past the write-back. A second instance has spare slots, and a third has fewer groups than slots. A restart in the middle of a run, a group in the same cycle as start, and groups beyond the round count are each driven on purpose, and the scoreboard holds no expected value for them.

// File: rtl/grp_fold_pkg.sv
package grp_fold_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_MERGE = 2'd2,
        ST_WAIT  = 2'd3
    } fold_state_e;

    // number of pairing levels needed to bring n values down to one
    function automatic int tree_levels(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

    // count of live values after lvl pairing levels
    function automatic int level_width(input int n, input int lvl);
        int w;
        w = n;
        for (int i = 0; i < lvl; i++) begin
            w = (w + 1) / 2;
        end
        return w;
    endfunction

    // index width that addresses n entries, at least one bit
    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gfr_adder_tree.sv
module gfr_adder_tree
    import grp_fold_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int ACC_W = 24,
    parameter int CONC  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    in_valid,
    input  logic [CONC*WIDTH-1:0]   in_data,
    output logic                    out_valid,
    output logic [ACC_W-1:0]        out_sum
);

    localparam int LEVELS = tree_levels(CONC);

    typedef logic [CONC-1:0][ACC_W-1:0] lane_vec_t;

    lane_vec_t lv_data [LEVELS+1];
    logic      lv_vld  [LEVELS+1];

    // neighbours 2j and 2j+1 combine; an odd tail value passes through
    function automatic lane_vec_t pair_up(input lane_vec_t v, input int n_in);
        lane_vec_t r;
        r = '0;
        for (int j = 0; j < CONC / 2; j++) begin
            if (2 * j + 1 < n_in) begin
                r[j] = v[2*j] + v[2*j+1];
            end
        end
        if (n_in % 2 == 1) begin
            r[n_in/2] = v[n_in-1];
        end
        return r;
    endfunction

    always_comb begin
        lv_data[0] = '0;
        for (int e = 0; e < CONC; e++) begin
            lv_data[0][e] = ACC_W'(in_data[e*WIDTH +: WIDTH]);
        end
        lv_vld[0] = in_valid;
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int N_IN = level_width(CONC, l);

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                lv_vld[l+1] <= 1'b0;
            end else begin
                lv_vld[l+1] <= lv_vld[l];
            end
            lv_data[l+1] <= pair_up(lv_data[l], N_IN);
        end
    end

    assign out_valid = lv_vld[LEVELS];
    assign out_sum   = lv_data[LEVELS][0];

endmodule

// File: rtl/gfr_lat_op.sv
module gfr_lat_op #(
    parameter int ACC_W   = 24,
    parameter int LATENCY = 3,
    parameter int TAG_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               in_valid,
    input  logic [ACC_W-1:0]   in_a,
    input  logic [ACC_W-1:0]   in_b,
    input  logic [TAG_W-1:0]   in_tag,
    output logic               out_valid,
    output logic [ACC_W-1:0]   out_sum,
    output logic [TAG_W-1:0]   out_tag,
    output logic               busy
);

    logic [ACC_W-1:0]   s_sum [LATENCY];
    logic [TAG_W-1:0]   s_tag [LATENCY];
    logic [LATENCY-1:0] s_vld;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            s_vld <= '0;
        end else begin
            s_vld[0] <= in_valid;
            for (int i = 1; i < LATENCY; i++) begin
                s_vld[i] <= s_vld[i-1];
            end
        end
        s_sum[0] <= in_a + in_b;
        s_tag[0] <= in_tag;
        for (int i = 1; i < LATENCY; i++) begin
            s_sum[i] <= s_sum[i-1];
            s_tag[i] <= s_tag[i-1];
        end
    end

    assign out_valid = s_vld[LATENCY-1];
    assign out_sum   = s_sum[LATENCY-1];
    assign out_tag   = s_tag[LATENCY-1];
    assign busy      = |s_vld;

endmodule

// File: rtl/gfr_slot_bank.sv
module gfr_slot_bank #(
    parameter int ACC_W    = 24,
    parameter int PIPESTEP = 3,
    parameter int SLOT_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 dw_en,
    input  logic [SLOT_W-1:0]    dw_idx,
    input  logic [ACC_W-1:0]     dw_data,
    input  logic                 wb_en,
    input  logic [SLOT_W-1:0]    wb_idx,
    input  logic [ACC_W-1:0]     wb_data,
    input  logic [SLOT_W-1:0]    fold_idx,
    output logic [ACC_W-1:0]     fold_data,
    input  logic [SLOT_W-1:0]    merge_idx,
    output logic [ACC_W-1:0]     merge_data,
    output logic [PIPESTEP-1:0]  written
);

    logic [ACC_W-1:0] slot_q [PIPESTEP];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            written <= '0;
        end else begin
            for (int s = 0; s < PIPESTEP; s++) begin
                if (dw_en && dw_idx == SLOT_W'(s)) begin
                    written[s] <= 1'b1;
                    slot_q[s]  <= dw_data;
                end else if (wb_en && wb_idx == SLOT_W'(s)) begin
                    slot_q[s]  <= wb_data;
                end
            end
        end
    end

    // a write-back landing in the cycle the slot is reused is forwarded
    assign fold_data  = (wb_en && wb_idx == fold_idx) ? wb_data : slot_q[fold_idx];
    assign merge_data = slot_q[merge_idx];

endmodule

// File: rtl/grp_fold_reducer.sv
module grp_fold_reducer
    import grp_fold_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int ACC_W    = 24,
    parameter int CONC     = 5,
    parameter int TOTAL    = 40,
    parameter int LATENCY  = 3,
    parameter int PIPESTEP = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   in_valid,
    input  logic [CONC*WIDTH-1:0]  in_data,
    output logic                   res_valid,
    output logic [ACC_W-1:0]       res_data
);

    localparam int ROUNDS = TOTAL / CONC;
    localparam int CNT_W  = $clog2(ROUNDS + 1);
    localparam int SLOT_W = idx_bits(PIPESTEP);
    localparam int MIDX_W = $clog2(PIPESTEP + 1);
    localparam logic [CNT_W-1:0]  ROUNDS_C = CNT_W'(ROUNDS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PIPESTEP - 1);
    localparam logic [MIDX_W-1:0] STEP_END  = MIDX_W'(PIPESTEP);

    fold_state_e         st;
    logic [CNT_W-1:0]    in_cnt;
    logic [CNT_W-1:0]    out_cnt;
    logic [SLOT_W-1:0]   ptr;
    logic [MIDX_W-1:0]   m_idx;
    logic [ACC_W-1:0]    acc;

    logic                accept;
    logic                grp_vld;
    logic [ACC_W-1:0]    grp_sum;
    logic                fold_issue;
    logic                direct_wr;
    logic                merge_issue;
    logic                m_done;

    logic                op_valid;
    logic [ACC_W-1:0]    op_a;
    logic [ACC_W-1:0]    op_b;
    logic                op_out_valid;
    logic [ACC_W-1:0]    op_out_sum;
    logic [SLOT_W-1:0]   op_out_tag;
    logic                op_busy;

    logic [ACC_W-1:0]    fold_data;
    logic [ACC_W-1:0]    merge_data;
    logic [SLOT_W-1:0]   merge_idx;
    logic [PIPESTEP-1:0] written;

    assign accept = (st == ST_RUN) && in_valid && !start && (in_cnt < ROUNDS_C);

    gfr_adder_tree #(
        .WIDTH (WIDTH),
        .ACC_W (ACC_W),
        .CONC  (CONC)
    ) u_tree (
        .clk       (clk),
        .rst       (rst),
        .flush     (start),
        .in_valid  (accept),
        .in_data   (in_data),
        .out_valid (grp_vld),
        .out_sum   (grp_sum)
    );

    assign direct_wr  = (st == ST_RUN) && grp_vld && !written[ptr];
    assign fold_issue = (st == ST_RUN) && grp_vld &&  written[ptr];

    always_comb begin
        if (m_idx >= STEP_END) begin
            m_done = 1'b1;
        end else begin
            m_done = !written[m_idx[SLOT_W-1:0]];
        end
    end

    assign merge_issue = (st == ST_MERGE) && !m_done;
    assign merge_idx   = (st == ST_RUN) ? '0 : m_idx[SLOT_W-1:0];

    assign op_valid = fold_issue || merge_issue;
    assign op_a     = merge_issue ? acc        : grp_sum;
    assign op_b     = merge_issue ? merge_data : fold_data;

    gfr_lat_op #(
        .ACC_W   (ACC_W),
        .LATENCY (LATENCY),
        .TAG_W   (SLOT_W)
    ) u_op (
        .clk       (clk),
        .rst       (rst),
        .flush     (start),
        .in_valid  (op_valid),
        .in_a      (op_a),
        .in_b      (op_b),
        .in_tag    (ptr),
        .out_valid (op_out_valid),
        .out_sum   (op_out_sum),
        .out_tag   (op_out_tag),
        .busy      (op_busy)
    );

    gfr_slot_bank #(
        .ACC_W    (ACC_W),
        .PIPESTEP (PIPESTEP),
        .SLOT_W   (SLOT_W)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .dw_en      (direct_wr),
        .dw_idx     (ptr),
        .dw_data    (grp_sum),
        .wb_en      ((st == ST_RUN) && op_out_valid),
        .wb_idx     (op_out_tag),
        .wb_data    (op_out_sum),
        .fold_idx   (ptr),
        .fold_data  (fold_data),
        .merge_idx  (merge_idx),
        .merge_data (merge_data),
        .written    (written)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            in_cnt    <= '0;
            out_cnt   <= '0;
            ptr       <= '0;
            m_idx     <= '0;
            acc       <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (start) begin
                st      <= ST_RUN;
                in_cnt  <= '0;
                out_cnt <= '0;
                ptr     <= '0;
            end else begin
                case (st)
                    ST_RUN: begin
                        if (accept) begin
                            in_cnt <= in_cnt + 1'b1;
                        end
                        if (grp_vld) begin
                            out_cnt <= out_cnt + 1'b1;
                            ptr     <= (ptr == LAST_SLOT) ? '0 : ptr + 1'b1;
                        end
                        if (out_cnt == ROUNDS_C && !op_busy) begin
                            acc   <= merge_data;
                            m_idx <= MIDX_W'(1);
                            st    <= ST_MERGE;
                        end
                    end
                    ST_MERGE: begin
                        if (m_done) begin
                            res_valid <= 1'b1;
                            res_data  <= acc;
                            st        <= ST_IDLE;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                    ST_WAIT: begin
                        if (op_out_valid) begin
                            acc   <= op_out_sum;
                            m_idx <= m_idx + 1'b1;
                            st    <= ST_MERGE;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/grp_fold_reducer_chk.sv
module grp_fold_reducer_chk
    import grp_fold_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int CNT_W  = 4,
    parameter int ROUNDS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               res_valid,
    input logic [ACC_W-1:0]   res_data,
    input fold_state_e        st,
    input logic [CNT_W-1:0]   in_cnt,
    input logic [CNT_W-1:0]   out_cnt,
    input logic               accept,
    input logic               op_busy,
    input logic               grp_vld
);

    localparam logic [CNT_W-1:0] ROUNDS_C = CNT_W'(ROUNDS);

    // R7
    res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_data));

    // R1
    round_cap_chk: assert property (@(posedge clk) disable iff (rst)
        in_cnt <= ROUNDS_C);

    // R1
    tree_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_cnt <= in_cnt);

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (in_cnt == '0 && out_cnt == '0 && st == ST_RUN));

    // R9
    idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !accept);

    // R6
    merge_drained_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MERGE) |-> !op_busy);

    // R5
    tree_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_RUN) |-> !grp_vld);

endmodule

bind grp_fold_reducer grp_fold_reducer_chk #(
    .ACC_W  (ACC_W),
    .CNT_W  (CNT_W),
    .ROUNDS (ROUNDS)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .res_valid (res_valid),
    .res_data  (res_data),
    .st        (st),
    .in_cnt    (in_cnt),
    .out_cnt   (out_cnt),
    .accept    (accept),
    .op_busy   (op_busy),
    .grp_vld   (grp_vld)
);

// File: tb/test_grp_fold_reducer.sv
`timescale 1ns/1ps
module test_grp_fold_reducer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        start_v [3];
    logic        vld_v   [3];
    logic [39:0] dat_v   [3];
    logic        rv_v    [3];
    logic [23:0] rd_v    [3];

    // 0: PIPESTEP == LATENCY, CONC 5, 8 rounds
    grp_fold_reducer #(.WIDTH(8), .ACC_W(24), .CONC(5), .TOTAL(40), .LATENCY(3), .PIPESTEP(3))
    i_grp_fold_reducer (
        .clk(clk), .rst(rst), .start(start_v[0]), .in_valid(vld_v[0]),
        .in_data(dat_v[0][39:0]), .res_valid(rv_v[0]), .res_data(rd_v[0]));

    // 1: PIPESTEP > LATENCY, CONC 4, 12 rounds
    grp_fold_reducer #(.WIDTH(8), .ACC_W(24), .CONC(4), .TOTAL(48), .LATENCY(2), .PIPESTEP(3))
    i_grp_fold_reducer_deep (
        .clk(clk), .rst(rst), .start(start_v[1]), .in_valid(vld_v[1]),
        .in_data(dat_v[1][31:0]), .res_valid(rv_v[1]), .res_data(rd_v[1]));

    // 2: fewer rounds (2) than slots (4), CONC 3
    grp_fold_reducer #(.WIDTH(8), .ACC_W(24), .CONC(3), .TOTAL(6), .LATENCY(2), .PIPESTEP(4))
    i_grp_fold_reducer_short (
        .clk(clk), .rst(rst), .start(start_v[2]), .in_valid(vld_v[2]),
        .in_data(dat_v[2][23:0]), .res_valid(rv_v[2]), .res_data(rd_v[2]));

    int checks = 0;
    int errors = 0;
    longint q0[$];
    longint q1[$];
    longint q2[$];
    int pushed [3] = '{0, 0, 0};
    int seen   [3] = '{0, 0, 0};
    bit prev_rv [3] = '{0, 0, 0};

    function automatic int conc_of(input int s);
        return (s == 0) ? 5 : (s == 1) ? 4 : 3;
    endfunction

    function automatic int rounds_of(input int s);
        return (s == 0) ? 8 : (s == 1) ? 12 : 2;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int qsize(input int s);
        return (s == 0) ? q0.size() : (s == 1) ? q1.size() : q2.size();
    endfunction

    function automatic longint qpop(input int s);
        if (s == 0) return q0.pop_front();
        if (s == 1) return q1.pop_front();
        return q2.pop_front();
    endfunction

    task automatic push(input int s, input longint v);
        longint m;
        m = v & 64'hFF_FFFF;
        if (s == 0) q0.push_back(m);
        else if (s == 1) q1.push_back(m);
        else q2.push_back(m);
        pushed[s]++;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int s = 0; s < 3; s++) begin
                if (rv_v[s]) begin
                    seen[s]++;
                    chk(!prev_rv[s], "R7 strobe longer than one cycle", 1, 0);
                    if (qsize(s) == 0) begin
                        chk(1'b0, "R9 or R8 unexpected result", longint'(rd_v[s]), -1);
                    end else begin
                        longint e;
                        e = qpop(s);
                        chk(longint'(rd_v[s]) == e, "R2 result value", longint'(rd_v[s]), e);
                    end
                end
                prev_rv[s] = rv_v[s];
            end
        end
    end

    task automatic do_start(input int s, input bit junk);
        @(posedge clk); #1;
        start_v[s] = 1'b1;
        if (junk) begin
            vld_v[s] = 1'b1;
            dat_v[s] = '1;
        end
        @(posedge clk); #1;
        start_v[s] = 1'b0;
        vld_v[s]   = 1'b0;
    endtask

    task automatic send_groups(input int s, input int n, input int gap_pct, output longint sum);
        int k;
        sum = 0;
        k = 0;
        while (k < n) begin
            @(posedge clk); #1;
            if ($urandom_range(99) < gap_pct) begin
                vld_v[s] = 1'b0;
                dat_v[s] = {$urandom, $urandom};
            end else begin
                logic [39:0] d;
                d = '0;
                for (int e = 0; e < conc_of(s); e++) begin
                    logic [7:0] b;
                    b = 8'($urandom_range(255));
                    d[e*8 +: 8] = b;
                    sum += longint'(b);
                end
                vld_v[s] = 1'b1;
                dat_v[s] = d;
                k++;
            end
        end
        @(posedge clk); #1;
        vld_v[s] = 1'b0;
    endtask

    task automatic wait_done(input int s);
        while (qsize(s) != 0) @(negedge clk);
    endtask

    task automatic full_run(input int s, input int gap_pct);
        longint sum;
        do_start(s, 1'b0);
        send_groups(s, rounds_of(s), gap_pct, sum);
        push(s, sum);
        wait_done(s);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        longint sum;
        longint junk_sum;
        for (int s = 0; s < 3; s++) begin
            start_v[s] = 1'b0;
            vld_v[s]   = 1'b0;
            dat_v[s]   = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R9: reset state
        @(negedge clk);
        for (int s = 0; s < 3; s++) begin
            chk(rv_v[s] == 1'b0, "R9 res_valid after reset", longint'(rv_v[s]), 0);
            chk(rd_v[s] == 24'd0, "R9 res_data after reset", longint'(rd_v[s]), 0);
        end

        // R9: groups before first start are ignored
        send_groups(0, 10, 0, junk_sum);
        repeat (30) @(posedge clk);
        chk(seen[0] == 0, "R9 idle groups produced result", seen[0], 0);

        // R2 R3 R4 R5: back-to-back groups, PIPESTEP == LATENCY forwarding
        full_run(0, 0);
        full_run(0, 0);

        // R7: result held after strobe
        begin
            logic [23:0] held;
            held = rd_v[0];
            repeat (7) @(negedge clk);
            chk(rd_v[0] == held, "R7 res_data held", longint'(rd_v[0]), longint'(held));
            chk(rv_v[0] == 1'b0, "R7 strobe low between results", longint'(rv_v[0]), 0);
        end

        // R3: idle cycles scattered through the stream
        for (int i = 0; i < 12; i++) full_run(0, 40);

        // R10: group coinciding with start is dropped
        do_start(0, 1'b1);
        send_groups(0, 8, 20, sum);
        push(0, sum);
        wait_done(0);

        // R1: groups beyond the round count are ignored
        do_start(0, 1'b0);
        send_groups(0, 8, 0, sum);
        push(0, sum);
        send_groups(0, 4, 0, junk_sum);
        wait_done(0);
        repeat (30) @(posedge clk);
        chk(seen[0] == pushed[0], "R1 one result per run", seen[0], pushed[0]);

        // R8: restart in the middle of a run
        do_start(0, 1'b0);
        send_groups(0, 5, 0, junk_sum);
        do_start(0, 1'b0);
        send_groups(0, 8, 30, sum);
        push(0, sum);
        wait_done(0);

        // R5: spare slots (PIPESTEP > LATENCY)
        full_run(1, 0);
        for (int i = 0; i < 12; i++) full_run(1, 35);

        // R6: fewer rounds than slots
        full_run(2, 0);
        for (int i = 0; i < 12; i++) full_run(2, 50);

        repeat (40) @(posedge clk);
        for (int s = 0; s < 3; s++) begin
            chk(seen[s] == pushed[s], "R1 result count", seen[s], pushed[s]);
        end
        summary();
        $finish;
    end

endmodule